// File: doc/BRIEF.md
# Biphase-Mark Stereo Subframe Encoder

This block turns one stereo audio frame into a line signal for a consumer or professional digital audio link. Every 128 master-clock cycles it takes a 24-bit sample for each channel and three flag bits per channel: validity, user and channel status. It also takes a flag that marks the first frame of a channel-status block. Each channel becomes a 32-slot subframe. The block adds a sync preamble and an even-parity bit, and sends the two subframes one after the other through a biphase-mark coder. The result drives a complementary output pair.

The master clock runs at 128 times the sample rate. Each frame therefore holds 64 code cells, and each half of a cell lasts exactly one clock. A one-cycle strobe tells the upstream logic when the next frame is about to be captured. A frame counter upstream decides which frame begins a block.

Top module: `bmc_subframe_tx`

## Requirements
- R1: While `rst_n` is low, `tx_p` and `tx_n` are both 0.
- R2: While `rst_n` is high, `tx_n` is always the inverse of `tx_p`.
- R3: `frm_ld` is high for exactly one cycle in every 128. The frame inputs are captured on the rising edge that ends that cycle. The level of half-cell k (0..127) of that frame appears on `tx_p` after the (k+1)-th rising edge that follows the capture edge.
- R4: Every data cell (slots 4..31) begins with a line transition. A cell carrying 1 has a second transition at mid-cell. A cell carrying 0 has none.
- R5: Half-cells 0..63 are the left subframe and 64..127 are the right subframe. Within a subframe, slot s covers half-cells 2s and 2s+1. Slot 4+i carries sample bit i (i = 0..23, so the sample is sent LSB first). Slot 28 carries the V flag (`*_vuc[2]`), slot 29 the U flag (`*_vuc[1]`) and slot 30 the C flag (`*_vuc[0]`).
- R6: Slot 31 holds a parity bit chosen so that slots 4..31 of each subframe together contain an even number of ones.
- R7: Slots 0..3 hold an 8-half-cell preamble, sent from its leftmost bit. The right subframe uses 11100100. The left subframe uses 11101000 when `blk_first` was high at capture, and 11100010 otherwise. The pattern is sent as written when the line was low just before it, and inverted when the line was high.
- R8: The first frame sent after reset is all-zero data and flags, with the plain left and right preambles, and the line level before it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 128 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| left_smp | input | 24 | Left-channel sample |
| right_smp | input | 24 | Right-channel sample |
| left_vuc | input | 3 | Left flags: [2] validity, [1] user, [0] channel status |
| right_vuc | input | 3 | Right flags, same layout |
| blk_first | input | 1 | Frame is the first of a channel-status block |
| frm_ld | output | 1 | Inputs are captured at the next rising edge |
| tx_p | output | 1 | Encoded line, true polarity |
| tx_n | output | 1 | Encoded line, inverted polarity |

## Verification
The embedded properties watch the line shape on every cycle. They check that each data cell opens with a transition, and that every preamble begins with a step away from the previous level followed by a three-half-cell flat run. They also check that the line returns, at the end of each subframe, to the level it had before that subframe's preamble, which is how even parity shows up on the wire. Only the bench scenarios can show that the right sample bit, flag and preamble land in the right slot, that the block-start flag selects the other left preamble only for the frame it was captured with, and that the capture strobe lines up with the frame boundary.

// File: rtl/bmc_subframe_tx.sv
module bmc_subframe_tx #(
  parameter int SMP_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SMP_W-1:0] left_smp,
  input  logic [SMP_W-1:0] right_smp,
  input  logic [2:0]       left_vuc,
  input  logic [2:0]       right_vuc,
  input  logic             blk_first,
  output logic             frm_ld,
  output logic             tx_p,
  output logic             tx_n
);

  localparam int         HALF_N  = 128;
  localparam int         PH_W    = $clog2(HALF_N);
  localparam int         WORD_W  = SMP_W + 3;
  localparam int         CELL_W  = WORD_W + 1;
  localparam logic [7:0] PRE_L   = 8'b11100010;
  localparam logic [7:0] PRE_R   = 8'b11100100;
  localparam logic [7:0] PRE_BLK = 8'b11101000;

  logic [PH_W-1:0]   ph;
  logic [SMP_W-1:0]  smp_l, smp_r;
  logic [2:0]        vuc_l, vuc_r;
  logic              blk_q;
  logic              line;
  logic              pre_lvl;

  logic              sub;
  logic [5:0]        h;
  logic [4:0]        slot;
  logic [4:0]        cidx;
  logic [WORD_W-1:0] word;
  logic [CELL_W-1:0] cells;
  logic [7:0]        pat;
  logic              pre_ref;
  logic              dbit;
  logic              nxt;

  assign sub   = ph[PH_W-1];
  assign h     = ph[5:0];
  assign slot  = h[5:1];
  assign cidx  = slot - 5'd4;
  assign word  = sub ? {vuc_r, smp_r} : {vuc_l, smp_l};
  assign cells = {^word, word[SMP_W], word[SMP_W+1], word[SMP_W+2], word[SMP_W-1:0]};
  assign dbit  = cells[cidx];
  assign pat   = sub ? PRE_R : (blk_q ? PRE_BLK : PRE_L);
  assign pre_ref = (h == 6'd0) ? line : pre_lvl;

  always_comb begin
    if (h < 6'd8)
      nxt = pat[3'd7 - h[2:0]] ^ pre_ref;
    else if (!h[0])
      nxt = ~line;
    else
      nxt = line ^ dbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= '0;
      line    <= 1'b0;
      pre_lvl <= 1'b0;
      smp_l   <= '0;
      smp_r   <= '0;
      vuc_l   <= '0;
      vuc_r   <= '0;
      blk_q   <= 1'b0;
    end else begin
      ph   <= ph + 1'b1;
      line <= nxt;
      if (h == 6'd0)
        pre_lvl <= line;
      if (frm_ld) begin
        smp_l <= left_smp;
        smp_r <= right_smp;
        vuc_l <= left_vuc;
        vuc_r <= right_vuc;
        blk_q <= blk_first;
      end
    end
  end

  assign frm_ld = (ph == PH_W'(HALF_N - 1));
  assign tx_p   = line & rst_n;
  assign tx_n   = ~line & rst_n;

  logic [PH_W-1:0] idx;
  assign idx = ph - 1'b1;

  AST_CELL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (idx[5:3] != 3'd0 && !idx[0]) |-> (line != $past(line)));  // R4

  AST_PRE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (idx[5:0] == 6'd0 && ph != 7'd0) |-> (line != pre_lvl));  // R7

  AST_PRE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (idx[5:0] == 6'd2) |-> (line == $past(line) && line == $past(line, 2)));  // R7

  AST_SUB_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (idx[5:0] == 6'd63) |-> (line == pre_lvl));  // R6

endmodule

// File: tb/bmc_subframe_tx_bench.sv
`timescale 1ns/1ps
module bmc_subframe_tx_bench;
  localparam int NF = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] left_smp = '0, right_smp = '0;
  logic [2:0]  left_vuc = '0, right_vuc = '0;
  logic        blk_first = 1'b0;
  logic        frm_ld, tx_p, tx_n;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  bmc_subframe_tx u_bmc_subframe_tx (
    .clk(clk), .rst_n(rst_n), .left_smp(left_smp), .right_smp(right_smp),
    .left_vuc(left_vuc), .right_vuc(right_vuc), .blk_first(blk_first),
    .frm_ld(frm_ld), .tx_p(tx_p), .tx_n(tx_n));

  logic [23:0] fa [NF];
  logic [23:0] fb [NF];
  logic [2:0]  va [NF];
  logic [2:0]  vb [NF];
  logic        fk [NF];

  task automatic check(input string req, input bit ok, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] model(input logic [23:0] a, input logic [23:0] b,
                                         input logic [2:0] fla, input logic [2:0] flb,
                                         input logic blk, input logic lvl0);
    logic [127:0] r;
    logic         lvl;
    logic [27:0]  c;
    logic [7:0]   pat;
    logic         inv;
    r = '0;
    lvl = lvl0;
    for (int s = 0; s < 2; s++) begin
      logic [23:0] smp;
      logic [2:0]  fl;
      smp = (s == 0) ? a : b;
      fl  = (s == 0) ? fla : flb;
      c[23:0] = smp;
      c[24] = fl[2];
      c[25] = fl[1];
      c[26] = fl[0];
      c[27] = ^{smp, fl};
      pat = (s == 1) ? 8'b11100100 : (blk ? 8'b11101000 : 8'b11100010);
      inv = lvl;
      for (int k = 0; k < 8; k++) begin
        lvl = pat[7-k] ^ inv;
        r[s*64+k] = lvl;
      end
      for (int sl = 4; sl < 32; sl++) begin
        lvl = ~lvl;
        r[s*64+2*sl] = lvl;
        if (c[sl-4]) lvl = ~lvl;
        r[s*64+2*sl+1] = lvl;
      end
    end
    return r;
  endfunction

  function automatic logic [127:0] region(input int lo, input int hi);
    logic [127:0] m;
    m = '0;
    for (int s = 0; s < 2; s++)
      for (int k = lo; k <= hi; k++) m[s*64+k] = 1'b1;
    return m;
  endfunction

  initial begin
    #(4 * 200000);
    fails++;
    tests++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [127:0] act, exp, m;
    logic         lvl_prev;
    bit           cmp_ok, ld_ok, tog_ok;
    int           seed;
    seed = $urandom(32'd4711);

    fa[0] = '0; fb[0] = '0; va[0] = '0; vb[0] = '0; fk[0] = 1'b0;
    fa[1] = 24'hFFFFFF; fb[1] = 24'h000000; va[1] = 3'b111; vb[1] = 3'b000; fk[1] = 1'b1;
    fa[2] = 24'h800001; fb[2] = 24'h7FFFFE; va[2] = 3'b101; vb[2] = 3'b010; fk[2] = 1'b0;
    fa[3] = 24'h000001; fb[3] = 24'hFFFFFF; va[3] = 3'b001; vb[3] = 3'b111; fk[3] = 1'b1;
    fa[4] = 24'hA5A5A5; fb[4] = 24'h5A5A5A; va[4] = 3'b100; vb[4] = 3'b011; fk[4] = 1'b0;
    for (int f = 5; f < NF; f++) begin
      fa[f] = 24'($urandom);
      fb[f] = 24'($urandom);
      va[f] = 3'($urandom);
      vb[f] = 3'($urandom);
      fk[f] = ($urandom % 4) == 0;
    end

    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1 reset idle", tx_p == 1'b0 && tx_n == 1'b0, {126'd0, tx_p, tx_n}, '0);
    end
    rst_n = 1'b1;

    lvl_prev = 1'b0;
    for (int f = 0; f < NF; f++) begin
      cmp_ok = 1'b1; ld_ok = 1'b1;
      for (int j = 0; j < 128; j++) begin
        @(negedge clk);
        act[j] = tx_p;
        if (tx_n !== ~tx_p) cmp_ok = 1'b0;
        if (frm_ld !== (j == 126)) ld_ok = 1'b0;
        if (j == 126 && f + 1 < NF) begin
          left_smp  = fa[f+1];
          right_smp = fb[f+1];
          left_vuc  = va[f+1];
          right_vuc = vb[f+1];
          blk_first = fk[f+1];
        end
      end
      exp = model(fa[f], fb[f], va[f], vb[f], fk[f], lvl_prev);
      lvl_prev = exp[127];
      check("R2 complementary pair", cmp_ok, act, exp);
      check("R3 capture strobe timing", ld_ok, act, exp);
      tog_ok = 1'b1;
      for (int s = 0; s < 2; s++)
        for (int sl = 4; sl < 32; sl++)
          if (act[s*64+2*sl] == act[s*64+2*sl-1]) tog_ok = 1'b0;
      check("R4 cell boundary transition", tog_ok, act, exp);
      m = region(0, 7);
      check("R7 preamble", (act & m) == (exp & m), act & m, exp & m);
      m = region(8, 55);
      check("R5 sample slots", (act & m) == (exp & m), act & m, exp & m);
      m = region(56, 61);
      check("R5 V/U/C slots", (act & m) == (exp & m), act & m, exp & m);
      m = region(62, 63);
      check("R6 parity slot", (act & m) == (exp & m), act & m, exp & m);
      if (f == 0)
        check("R8 first frame after reset", act == exp, act, exp);
    end

    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 reset during operation", tx_p == 1'b0 && tx_n == 1'b0, {126'd0, tx_p, tx_n}, '0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule